// File: doc/BRIEF.md
# Programmable Interrupt Routing Controller

This block gathers a set of external interrupt request lines and turns each one into a vector message for a local interrupt acceptor. Software configures each line through a redirection entry. The entry selects the vector, a delivery mode, edge or level behaviour, and a mask. Edge lines report each rising transition once. Level lines report once and then hold a remote-pending flag. An end-of-interrupt broadcast that carries the line's vector clears that flag.

Software reaches the internal registers indirectly. An 8-bit select register names an index, and a 32-bit data window reads or writes the register at that index. Messages leave on a single valid/ready channel that carries the vector and the trigger mode. When several lines are pending at once, a fixed priority serves the highest-numbered line first. Request lines pass through a two-flop synchronizer before any edge or level decision is made.

Top module: `irq_router`

## Requirements
- R1: Register index 0x00 is the identity register. Only bits 27:24 are writable. All other bits read 0, and the register reads 0 after reset.
- R2: Register index 0x01 is read-only and reads {8'h00, NUM_LINES-1, 8'h00, VER_CODE}. That is 0x00170020 with the default parameters, and no write changes it.
- R3: Register index 0x02 is read-only. Its bits 27:24 hold the bits 27:24 of the last write to index 0x00, its other bits read 0, and writes to index 0x02 are ignored.
- R4: Line i owns index 0x10+2i (low word) and index 0x11+2i (high word). The low word holds vector in bits 7:0, delivery mode in bits 10:8, trigger mode in bit 15 (1 = level, 0 = edge) and mask in bit 16, and its other bits read 0. The high word always reads 0.
- R5: An unmasked edge line produces exactly one message per rising transition, even for a one-cycle pulse.
- R6: A rising transition on a masked edge line is discarded. Clearing the mask alone produces no message, and a later rising edge does.
- R7: An unmasked level line that is high produces one message and sets its remote-pending flag. No further message leaves for that line while the flag is set, even if the line drops and rises again.
- R8: An end-of-interrupt whose vector equals a level line's vector clears that line's remote-pending flag. If the line is still high and unmasked, it is delivered again. An end-of-interrupt with a different vector has no effect.
- R9: A level line that is high while masked sends nothing. When the mask is cleared with the line still high, one message is sent. This also holds when the mask was set during service and the end-of-interrupt arrived while masked.
- R10: When several lines request in the same cycle, the highest-numbered line is sent first and the lower one follows.
- R11: Each message carries the entry's vector on msg_vector and its trigger mode on msg_level. While msg_valid is high and msg_ready is low, the message stays valid and unchanged.
- R12: After reset every entry is masked, its low word reads 0x00010000, msg_valid is low, and activity on the lines produces no message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_LINES | Asynchronous interrupt request lines |
| sel_we | input | 1 | Load the register select |
| sel_wdata | input | 8 | New register index |
| win_we | input | 1 | Write the selected register |
| win_wdata | input | 32 | Data for the selected register |
| win_rdata | output | 32 | Contents of the selected register |
| eoi_valid | input | 1 | End-of-interrupt broadcast strobe |
| eoi_vector | input | 8 | Vector of the end-of-interrupt |
| msg_valid | output | 1 | A message is offered |
| msg_vector | output | 8 | Vector of the offered message |
| msg_level | output | 1 | Trigger mode of the offered message (1 = level) |
| msg_ready | input | 1 | The acceptor takes the message |

## Verification
The edge path is swept across every line with a one-cycle pulse. Each pulse must yield exactly one message with that line's vector, which shows that per-line routing and the narrow-pulse capture both work.

Level behaviour is exercised in four ways:
- a line that drops and rises again while remote-pending, which separates coalescing from re-triggering;
- end-of-interrupt broadcasts with a matching and a non-matching vector;
- end-of-interrupt broadcasts with the line high and with the line low;
- masking both before the line rises and in the middle of service.

Two edge lines raised in the same cycle with the acceptor stalled expose the priority order and the hold of a stalled message. Register writes use all-ones and mixed patterns, which distinguishes writable bits from fixed bits in the identity, version, arbitration and entry words.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;

    localparam logic [7:0] IDX_ID   = 8'h00;
    localparam logic [7:0] IDX_VER  = 8'h01;
    localparam logic [7:0] IDX_ARB  = 8'h02;
    localparam logic [7:0] ENT_BASE = 8'h10;

    typedef struct packed {
        logic [7:0] vec;
        logic [2:0] dmode;
        logic       lvl;
        logic       mask;
    } redir_t;

    localparam redir_t ENT_RESET = '{vec: 8'h00, dmode: 3'd0, lvl: 1'b0, mask: 1'b1};

    function automatic logic [31:0] ent_to_word(redir_t e);
        return {15'd0, e.mask, e.lvl, 4'd0, e.dmode, e.vec};
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] stab_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            stab_q <= '0;
        end else begin
            meta_q <= d;
            stab_q <= meta_q;
        end
    end

    assign q = stab_q;
endmodule

// File: rtl/irq_line_ctl.sv
module irq_line_ctl (
    input  logic       clk,
    input  logic       rst,
    input  logic       line_lvl,
    input  logic [7:0] cfg_vec,
    input  logic       cfg_level,
    input  logic       cfg_mask,
    input  logic       grant,
    input  logic       eoi_valid,
    input  logic [7:0] eoi_vector,
    output logic       req
);
    logic prev_q;
    logic edge_pend_q;
    logic rirr_q;
    logic rise;
    logic eoi_hit;

    assign rise    = line_lvl & ~prev_q;
    assign eoi_hit = eoi_valid && (eoi_vector == cfg_vec);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q      <= 1'b0;
            edge_pend_q <= 1'b0;
            rirr_q      <= 1'b0;
        end else begin
            prev_q <= line_lvl;
            if (cfg_level)
                edge_pend_q <= 1'b0;
            else if (rise && !cfg_mask)
                edge_pend_q <= 1'b1;
            else if (grant)
                edge_pend_q <= 1'b0;
            if (grant && cfg_level)
                rirr_q <= 1'b1;
            else if (eoi_hit)
                rirr_q <= 1'b0;
        end
    end

    assign req = cfg_level ? (line_lvl & ~cfg_mask & ~rirr_q)
                           : (edge_pend_q & ~cfg_mask);

    // R6
    masked_edge_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (!cfg_level && cfg_mask && !edge_pend_q) |=> !edge_pend_q);

    // R7
    level_grant_rirr_chk: assert property (@(posedge clk) disable iff (rst)
        (grant && cfg_level && !eoi_hit) |=> rirr_q);
endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
    parameter int N  = 24,
    parameter int IW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  win,
    output logic [IW-1:0] win_idx,
    output logic          any
);
    always_comb begin
        win     = '0;
        win_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i]) begin
                win     = '0;
                win[i]  = 1'b1;
                win_idx = IW'(i);
            end
        end
    end

    assign any = |req;

    // R10
    pick_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(win) && (any == (win != '0)));
endmodule

// File: rtl/irq_router.sv
module irq_router
    import irq_router_pkg::*;
#(
    parameter int         NUM_LINES = 24,
    parameter logic [7:0] VER_CODE  = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LINES-1:0] irq_in,
    input  logic                 sel_we,
    input  logic [7:0]           sel_wdata,
    input  logic                 win_we,
    input  logic [31:0]          win_wdata,
    output logic [31:0]          win_rdata,
    input  logic                 eoi_valid,
    input  logic [7:0]           eoi_vector,
    output logic                 msg_valid,
    output logic [7:0]           msg_vector,
    output logic                 msg_level,
    input  logic                 msg_ready
);
    localparam int          LW       = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1;
    localparam logic [7:0]  ENT_SPAN = 8'(2 * NUM_LINES);
    localparam logic [31:0] VER_WORD = {8'h00, 8'(NUM_LINES - 1), 8'h00, VER_CODE};

    logic [7:0]           sel_q;
    logic [3:0]           id_q;
    logic [3:0]           arb_q;
    redir_t               ent_q [NUM_LINES];
    logic [7:0]           ent_off;
    logic                 is_ent;
    logic [LW-1:0]        ent_idx;
    logic [NUM_LINES-1:0] lines_s;
    logic [NUM_LINES-1:0] req;
    logic [NUM_LINES-1:0] win;
    logic [NUM_LINES-1:0] grant;
    logic [LW-1:0]        win_idx;
    logic                 any_req;
    logic                 load;
    logic                 unused_wbits;

    assign ent_off      = sel_q - ENT_BASE;
    assign is_ent       = ent_off < ENT_SPAN;
    assign ent_idx      = ent_off[LW:1];
    assign unused_wbits = ^{win_wdata[31:28], win_wdata[23:17], win_wdata[14:11]};

    // register file
    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= '0;
            arb_q <= '0;
            for (int i = 0; i < NUM_LINES; i++) ent_q[i] <= ENT_RESET;
        end else begin
            if (sel_we) sel_q <= sel_wdata;
            if (win_we && sel_q == IDX_ID) begin
                id_q  <= win_wdata[27:24];
                arb_q <= win_wdata[27:24];
            end
            for (int i = 0; i < NUM_LINES; i++) begin
                if (win_we && is_ent && !ent_off[0] && ent_idx == LW'(i))
                    ent_q[i] <= '{vec: win_wdata[7:0], dmode: win_wdata[10:8],
                                  lvl: win_wdata[15], mask: win_wdata[16]};
            end
        end
    end

    always_comb begin
        win_rdata = 32'h0;
        if (sel_q == IDX_ID)
            win_rdata = {4'h0, id_q, 24'h0};
        else if (sel_q == IDX_VER)
            win_rdata = VER_WORD;
        else if (sel_q == IDX_ARB)
            win_rdata = {4'h0, arb_q, 24'h0};
        else if (is_ent && !ent_off[0])
            win_rdata = ent_to_word(ent_q[ent_idx]);
    end

    irq_sync #(.W(NUM_LINES)) u_sync (
        .clk(clk), .rst(rst), .d(irq_in), .q(lines_s)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        irq_line_ctl u_ctl (
            .clk       (clk),
            .rst       (rst),
            .line_lvl  (lines_s[g]),
            .cfg_vec   (ent_q[g].vec),
            .cfg_level (ent_q[g].lvl),
            .cfg_mask  (ent_q[g].mask),
            .grant     (grant[g]),
            .eoi_valid (eoi_valid),
            .eoi_vector(eoi_vector),
            .req       (req[g])
        );
    end

    irq_pick #(.N(NUM_LINES), .IW(LW)) u_pick (
        .clk(clk), .rst(rst), .req(req), .win(win), .win_idx(win_idx), .any(any_req)
    );

    assign load  = any_req && (!msg_valid || msg_ready);
    assign grant = load ? win : '0;

    // message output stage
    always_ff @(posedge clk) begin
        if (rst) begin
            msg_valid  <= 1'b0;
            msg_vector <= '0;
            msg_level  <= 1'b0;
        end else if (load) begin
            msg_valid  <= 1'b1;
            msg_vector <= ent_q[win_idx].vec;
            msg_level  <= ent_q[win_idx].lvl;
        end else if (msg_ready) begin
            msg_valid  <= 1'b0;
        end
    end

    // R11
    msg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) && $stable(msg_level)));

    // R3
    arb_ro_chk: assert property (@(posedge clk) disable iff (rst)
        (win_we && sel_q == IDX_ARB) |=> $stable(arb_q));
endmodule

// File: tb/sim_irq_router.sv
`timescale 1ns/100ps
module sim_irq_router;
    localparam int N = 24;
    localparam logic [31:0] VER_EXP = 32'h00170020;
    localparam logic [31:0] LVL_BIT = 32'h0000_8000;
    localparam logic [31:0] MSK_BIT = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [N-1:0] irq_in = '0;
    logic        sel_we = 1'b0;
    logic [7:0]  sel_wdata = '0;
    logic        win_we = 1'b0;
    logic [31:0] win_wdata = '0;
    logic [31:0] win_rdata;
    logic        eoi_valid = 1'b0;
    logic [7:0]  eoi_vector = '0;
    logic        msg_valid;
    logic [7:0]  msg_vector;
    logic        msg_level;
    logic        msg_ready = 1'b1;

    int n_chk = 0;
    int n_fail = 0;
    int msg_cnt = 0;
    logic [7:0] vec_log [0:127];
    logic       lvl_log [0:127];
    logic [31:0] rd;
    int base;

    always #2.5 clk = ~clk;

    irq_router u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in),
        .sel_we(sel_we), .sel_wdata(sel_wdata),
        .win_we(win_we), .win_wdata(win_wdata), .win_rdata(win_rdata),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_vector(msg_vector), .msg_level(msg_level),
        .msg_ready(msg_ready)
    );

    always @(negedge clk) begin
        #1;
        if (!rst && msg_valid && msg_ready && msg_cnt < 128) begin
            vec_log[msg_cnt] = msg_vector;
            lvl_log[msg_cnt] = msg_level;
            msg_cnt = msg_cnt + 1;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [31:0] d);
        @(negedge clk); sel_we = 1'b1; sel_wdata = idx;
        @(negedge clk); sel_we = 1'b0; win_we = 1'b1; win_wdata = d;
        @(negedge clk); win_we = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] idx, output logic [31:0] d);
        @(negedge clk); sel_we = 1'b1; sel_wdata = idx;
        @(negedge clk); sel_we = 1'b0;
        #1 d = win_rdata;
    endtask

    task automatic pulse(input int line);
        @(negedge clk); irq_in[line] = 1'b1;
        @(negedge clk); irq_in[line] = 1'b0;
    endtask

    task automatic send_eoi(input logic [7:0] v);
        @(negedge clk); eoi_valid = 1'b1; eoi_vector = v;
        @(negedge clk); eoi_valid = 1'b0;
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle(4);
        rst = 1'b0;
        idle(2);

        // R12 reset state
        chk("R12 msg_valid after reset", {31'd0, msg_valid}, 32'd0);
        reg_rd(8'h10, rd);      chk("R12 entry0 reset word", rd, 32'h0001_0000);
        reg_rd(8'h10 + 8'd46, rd); chk("R12 entry23 reset word", rd, 32'h0001_0000);
        reg_rd(8'h00, rd);      chk("R1 id reset", rd, 32'h0);
        @(negedge clk); irq_in[5] = 1'b1; idle(10); irq_in[5] = 1'b0; idle(6);
        chk("R12 masked lines silent", msg_cnt, 0);

        // R1 identity register
        reg_wr(8'h00, 32'hFFFF_FFFF); reg_rd(8'h00, rd); chk("R1 id all ones", rd, 32'h0F00_0000);
        reg_wr(8'h00, 32'h0000_0000); reg_rd(8'h00, rd); chk("R1 id cleared", rd, 32'h0);

        // R2 version register
        reg_rd(8'h01, rd); chk("R2 version value", rd, VER_EXP);
        reg_wr(8'h01, ~VER_EXP); reg_rd(8'h01, rd); chk("R2 version after write", rd, VER_EXP);

        // R3 arbitration register
        reg_wr(8'h00, 32'h5A5A_5A5A); reg_rd(8'h02, rd); chk("R3 arb follows id", rd, 32'h0A00_0000);
        reg_wr(8'h02, 32'h0000_0000); reg_rd(8'h02, rd); chk("R3 arb write ignored", rd, 32'h0A00_0000);
        reg_wr(8'h00, 32'hF0FF_FFFF); reg_rd(8'h02, rd); chk("R3 arb follows zero", rd, 32'h0);

        // R4 entry layout
        reg_wr(8'h16, 32'hFFFF_FFFF); reg_rd(8'h16, rd); chk("R4 low word fields", rd, 32'h0001_87FF);
        reg_wr(8'h17, 32'hFFFF_FFFF); reg_rd(8'h17, rd); chk("R4 high word zero", rd, 32'h0);
        reg_wr(8'h16, MSK_BIT);

        // R5 edge sweep over every line, one-cycle pulse
        for (int i = 0; i < N; i++) begin
            reg_wr(8'h10 + 8'(2 * i), 32'h30 + 32'(i));
            base = msg_cnt;
            pulse(i);
            idle(10);
            chk($sformatf("R5 edge count line %0d", i), msg_cnt - base, 1);
            if (msg_cnt > base) begin
                chk($sformatf("R11 edge vector line %0d", i), {24'd0, vec_log[base]}, 32'h30 + 32'(i));
                chk($sformatf("R11 edge trig line %0d", i), {31'd0, lvl_log[base]}, 32'd0);
            end
        end

        // R6 masked edge dropped
        reg_wr(8'h14, MSK_BIT | 32'h32);
        base = msg_cnt;
        pulse(2); idle(10);
        chk("R6 masked edge dropped", msg_cnt - base, 0);
        reg_wr(8'h14, 32'h32); idle(10);
        chk("R6 unmask gives nothing", msg_cnt - base, 0);
        pulse(2); idle(10);
        chk("R6 new edge delivered", msg_cnt - base, 1);

        // R10 priority with stalled acceptor, R11 hold
        @(negedge clk); msg_ready = 1'b0; irq_in[1] = 1'b1; irq_in[4] = 1'b1;
        @(negedge clk); irq_in[1] = 1'b0; irq_in[4] = 1'b0;
        base = msg_cnt;
        idle(8);
        #1 chk("R11 stalled valid", {31'd0, msg_valid}, 32'd1);
        chk("R10 first offered", {24'd0, msg_vector}, 32'h34);
        idle(3);
        #1 chk("R11 stalled vector stable", {24'd0, msg_vector}, 32'h34);
        @(negedge clk); msg_ready = 1'b1;
        idle(10);
        chk("R10 both delivered", msg_cnt - base, 2);
        chk("R10 high line first", {24'd0, vec_log[base]}, 32'h34);
        chk("R10 low line second", {24'd0, vec_log[base + 1]}, 32'h31);

        // R7 level delivery and coalescing
        reg_wr(8'h1E, LVL_BIT | 32'h77);
        base = msg_cnt;
        @(negedge clk); irq_in[7] = 1'b1; idle(10);
        chk("R7 level one message", msg_cnt - base, 1);
        chk("R11 level trig flag", {31'd0, lvl_log[base]}, 32'd1);
        chk("R11 level vector", {24'd0, vec_log[base]}, 32'h77);
        @(negedge clk); irq_in[7] = 1'b0; idle(4); irq_in[7] = 1'b1; idle(10);
        chk("R7 coalesced while pending", msg_cnt - base, 1);

        // R8 end-of-interrupt
        send_eoi(8'h55); idle(10);
        chk("R8 other vector ignored", msg_cnt - base, 1);
        send_eoi(8'h77); idle(10);
        chk("R8 redelivered while high", msg_cnt - base, 2);
        @(negedge clk); irq_in[7] = 1'b0; idle(4);
        send_eoi(8'h77); idle(10);
        chk("R8 no delivery when low", msg_cnt - base, 2);

        // R9 level with mask
        reg_wr(8'h1E, MSK_BIT | LVL_BIT | 32'h77);
        base = msg_cnt;
        @(negedge clk); irq_in[7] = 1'b1; idle(10);
        chk("R9 masked level silent", msg_cnt - base, 0);
        reg_wr(8'h1E, LVL_BIT | 32'h77); idle(10);
        chk("R9 unmask delivers", msg_cnt - base, 1);
        reg_wr(8'h1E, MSK_BIT | LVL_BIT | 32'h77);
        send_eoi(8'h77); idle(10);
        chk("R9 eoi while masked silent", msg_cnt - base, 1);
        reg_wr(8'h1E, LVL_BIT | 32'h77); idle(10);
        chk("R9 unmask after service delivers", msg_cnt - base, 2);
        @(negedge clk); irq_in[7] = 1'b0;
        send_eoi(8'h77); idle(6);

        summary();
    end
endmodule